// File: doc/BRIEF.md
# Eight-Function Combinational ALU

This block computes one of eight arithmetic, shift or bitwise functions of two operands and returns a single result word. It has no clock and no storage, so the result follows its inputs within the same time step. A 3-bit function code picks the operation. A separate 4-bit shift count is used only by the shift function.

Add and subtract share one parallel-prefix (Kogge-Stone) adder. Subtract feeds the adder the inverted second operand with a carry-in of one. Multiply is a combinational array that keeps only the low half of the product. The shift function moves the second operand right through a logarithmic barrel of stages and fills the vacated high bits with zeros. Overflow and condition flags are not produced.

Top module: `alu8`

## Requirements
- R1: With func = 3'b000, result equals (op_a + op_b) modulo 2^16.
- R2: With func = 3'b001, result equals (op_a - op_b) modulo 2^16 (two's complement wrap).
- R3: With func = 3'b010, result equals the low 16 bits of the 32-bit product op_a * op_b.
- R4: With func = 3'b011, result equals op_b shifted right logically by shamt (0 to 15), high bits zero-filled, and op_a has no effect on it.
- R5: With func = 3'b100, result equals the bitwise NOR of op_a and op_b.
- R6: With func = 3'b101, result equals the bitwise AND of op_a and op_b.
- R7: With func = 3'b110, result equals the bitwise OR of op_a and op_b.
- R8: With func = 3'b111, result equals the bitwise XOR of op_a and op_b.
- R9: For every func other than 3'b011, shamt has no effect on result.
- R10: result is a pure function of the present inputs: the same inputs give the same result whatever was applied before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand, also the shift source |
| shamt | input | 4 | Right-shift count for func 3'b011 |
| func | input | 3 | Function select |
| result | output | 16 | Selected function of the operands |

## Verification
On every input change the checker tests inverse relations of each function. For add, result minus op_b gives op_a back. For subtract, result plus op_b does. The bitwise results are tested for subset and superset containment against the operands. For the shift, the checker confirms zero fill of the top shamt bits and that the surviving bits line up with op_b. It also checks the low product bit and multiplication by one. The exact product values and the wrap cases at the operand limits are shown only by the bench's vectors. So are the independence of the result from shamt and from earlier inputs, since these involve pairs of applications rather than one input set.

// File: rtl/alu8.sv
module alu8 #(
  parameter int W = 16,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  op_a,
  input  logic [W-1:0]  op_b,
  input  logic [SW-1:0] shamt,
  input  logic [2:0]    func,
  output logic [W-1:0]  result
);

  localparam int LV = SW;

  logic          sub;
  logic [W-1:0]  bb;
  logic [W-1:0]  p0;
  logic [W-1:0]  carry;
  logic [W-1:0]  sum;

  assign sub = (func == 3'b001);
  assign bb  = sub ? ~op_b : op_b;
  assign p0  = op_a ^ bb;

  logic [LV:0][W-2:0] gk;
  logic [LV:0][W-2:0] pk;

  genvar i, l;
  generate
    for (i = 0; i < W-1; i++) begin : g_init
      if (i == 0) begin : g_cin
        assign gk[0][i] = (op_a[i] & bb[i]) | (p0[i] & sub);
      end else begin : g_plain
        assign gk[0][i] = op_a[i] & bb[i];
      end
      assign pk[0][i] = p0[i];
    end

    for (l = 0; l < LV; l++) begin : g_lvl
      localparam int D = 1 << l;
      for (i = 0; i < W-1; i++) begin : g_bit
        if (i >= D) begin : g_cell
          assign gk[l+1][i] = gk[l][i] | (pk[l][i] & gk[l][i-D]);
          assign pk[l+1][i] = pk[l][i] & pk[l][i-D];
        end else begin : g_buf
          assign gk[l+1][i] = gk[l][i];
          assign pk[l+1][i] = pk[l][i];
        end
      end
    end
  endgenerate

  assign carry = {gk[LV], sub};
  assign sum   = p0 ^ carry;

  logic [W:0][W-1:0] acc;
  assign acc[0] = '0;
  generate
    for (i = 0; i < W; i++) begin : g_row
      assign acc[i+1] = acc[i] + ((op_a & {W{op_b[i]}}) << i);
    end
  endgenerate

  logic [SW:0][W-1:0] sh;
  assign sh[0] = op_b;
  generate
    for (l = 0; l < SW; l++) begin : g_shift
      assign sh[l+1] = shamt[l] ? (sh[l] >> (1 << l)) : sh[l];
    end
  endgenerate

  always_comb begin
    case (func)
      3'b000, 3'b001: result = sum;
      3'b010:         result = acc[W];
      3'b011:         result = sh[SW];
      3'b100:         result = ~(op_a | op_b);
      3'b101:         result = op_a & op_b;
      3'b110:         result = op_a | op_b;
      default:        result = op_a ^ op_b;
    endcase
  end

endmodule

module alu8_chk #(
  parameter int W = 16,
  parameter int SW = $clog2(W)
) (
  input logic [W-1:0]  op_a,
  input logic [W-1:0]  op_b,
  input logic [SW-1:0] shamt,
  input logic [2:0]    func,
  input logic [W-1:0]  result
);
  localparam logic [W-1:0] ONES = '1;

  always_comb begin
    if (func == 3'b000) a_r1_add_inverse: assert ((result - op_b) == op_a);
    if (func == 3'b001) a_r2_sub_inverse: assert ((result + op_b) == op_a);
    if (func == 3'b010) a_r3_low_bit: assert (result[0] == (op_a[0] & op_b[0]));
    if (func == 3'b010 && op_b == 1) a_r3_times_one: assert (result == op_a);
    if (func == 3'b011) a_r4_aligned: assert ((result << shamt) == (op_b & (ONES << shamt)));
    if (func == 3'b011 && shamt != 0) a_r4_zero_fill: assert ((result >> (W - int'(shamt))) == '0);
    if (func == 3'b100) a_r5_nor: assert (((result & (op_a | op_b)) == '0) && ((result | op_a | op_b) == ONES));
    if (func == 3'b101) a_r6_and: assert (((result & ~op_a) == '0) && ((result & ~op_b) == '0) && ((result | ~(op_a & op_b)) == ONES));
    if (func == 3'b110) a_r7_or: assert (((result & op_a) == op_a) && ((result & op_b) == op_b) && ((result & ~(op_a | op_b)) == '0));
    if (func == 3'b111) a_r8_xor: assert ((result ^ op_b) == op_a);
  end
endmodule

bind alu8 alu8_chk #(.W(W), .SW(SW)) u_chk (
  .op_a(op_a), .op_b(op_b), .shamt(shamt), .func(func), .result(result)
);

// File: tb/test_alu8.sv
module test_alu8;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] op_a = '0, op_b = '0;
  logic [3:0]  shamt = '0;
  logic [2:0]  func = '0;
  logic [15:0] result;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  alu8 i_alu8 (.op_a(op_a), .op_b(op_b), .shamt(shamt), .func(func), .result(result));

  localparam int NV = 16;
  localparam logic [54:0] VEC [NV] = '{
    {3'd0, 4'd0,  16'h1234, 16'h4321, 16'h5555},
    {3'd0, 4'd0,  16'hFFFF, 16'h0001, 16'h0000},
    {3'd1, 4'd0,  16'h0005, 16'h0007, 16'hFFFE},
    {3'd1, 4'd0,  16'h8000, 16'h0001, 16'h7FFF},
    {3'd2, 4'd0,  16'h0003, 16'h0005, 16'h000F},
    {3'd2, 4'd0,  16'h0100, 16'h0100, 16'h0000},
    {3'd2, 4'd0,  16'hFFFF, 16'hFFFF, 16'h0001},
    {3'd2, 4'd0,  16'h1234, 16'h0010, 16'h2340},
    {3'd3, 4'd15, 16'hFFFF, 16'h8000, 16'h0001},
    {3'd3, 4'd4,  16'h0000, 16'hF0F0, 16'h0F0F},
    {3'd3, 4'd0,  16'h5A5A, 16'hABCD, 16'hABCD},
    {3'd3, 4'd8,  16'h1111, 16'h1234, 16'h0012},
    {3'd4, 4'd0,  16'hF0F0, 16'h0FF0, 16'h000F},
    {3'd5, 4'd0,  16'hF0F0, 16'h0FF0, 16'h00F0},
    {3'd6, 4'd0,  16'hF0F0, 16'h0FF0, 16'hFFF0},
    {3'd7, 4'd0,  16'hF0F0, 16'h0FF0, 16'hFF00}
  };

  function automatic logic [15:0] model(input logic [2:0] f, input logic [15:0] a,
                                        input logic [15:0] b, input logic [3:0] s);
    logic [31:0] prod;
    prod = 32'(a) * 32'(b);
    case (f)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return prod[15:0];
      3'd3: return b >> s;
      3'd4: return ~(a | b);
      3'd5: return a & b;
      3'd6: return a | b;
      default: return a ^ b;
    endcase
  endfunction

  task automatic apply(input logic [2:0] f, input logic [3:0] s,
                       input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    func = f; shamt = s; op_a = a; op_b = b;
    #1;
  endtask

  task automatic check(input string req, input logic [15:0] exp);
    checks++;
    if (result !== exp) begin
      errors++;
      $display("FAIL %s func=%0d a=%h b=%h shamt=%0d actual=%h expected=%h",
               req, func, op_a, op_b, shamt, result, exp);
    end
  endtask

  function automatic string tag(input logic [2:0] f);
    case (f)
      3'd0: return "R1"; 3'd1: return "R2"; 3'd2: return "R3"; 3'd3: return "R4";
      3'd4: return "R5"; 3'd5: return "R6"; 3'd6: return "R7"; default: return "R8";
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 zero inputs", 16'h0000);

    for (int k = 0; k < NV; k++) begin
      apply(VEC[k][54:52], VEC[k][51:48], VEC[k][47:32], VEC[k][31:16]);
      check(tag(VEC[k][54:52]), VEC[k][15:0]);
    end

    begin
      logic [31:0] lcg = 32'h1ACE_5EED;
      for (int k = 0; k < 400; k++) begin
        logic [2:0] f; logic [3:0] s; logic [15:0] a, b;
        lcg = lcg * 32'd1664525 + 32'd1013904223; a = lcg[31:16];
        lcg = lcg * 32'd1664525 + 32'd1013904223; b = lcg[31:16];
        lcg = lcg * 32'd1664525 + 32'd1013904223; f = lcg[18:16]; s = lcg[23:20];
        apply(f, s, a, b);
        check(tag(f), model(f, a, b, s));
      end
    end

    apply(3'd3, 4'd5, 16'h0000, 16'hC3A5);
    check("R4 op_a zero", 16'h061D);
    apply(3'd3, 4'd5, 16'hFFFF, 16'hC3A5);
    check("R4 op_a ignored", 16'h061D);

    for (int f = 0; f < 8; f++) begin
      if (f == 3) continue;
      apply(3'(f), 4'd0, 16'h9E37, 16'h79B9);
      check("R9 shamt 0", model(3'(f), 16'h9E37, 16'h79B9, 4'd0));
      apply(3'(f), 4'd13, 16'h9E37, 16'h79B9);
      check("R9 shamt 13", model(3'(f), 16'h9E37, 16'h79B9, 4'd0));
    end

    apply(3'd1, 4'd0, 16'h0000, 16'h0001);
    check("R10 first", 16'hFFFF);
    apply(3'd2, 4'd0, 16'hFFFF, 16'hFFFF);
    apply(3'd3, 4'd15, 16'h1234, 16'hFFFF);
    apply(3'd1, 4'd0, 16'h0000, 16'h0001);
    check("R10 repeat", 16'hFFFF);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule